// File: doc/BRIEF.md
# Cycle-Steal Input Request Unit

This unit sits on the peripheral side of a processor that supports cycle-steal input transfers. When the device has a byte ready, it pulses a one-cycle enter strobe. The unit captures the byte and pulls an active-low transfer request low. It keeps the request low until the processor grants a stolen cycle.

The processor reports its machine state on a two-bit state code. That code can be briefly invalid while the state changes, so the unit reads it only on clock edges where the TPA timing pulse is high. When a sample shows the transfer-cycle code, the unit does three things:
- it drives the captured byte onto the shared data bus;
- it raises a bus-enable;
- it releases the request, unless a fresh strobe arrives in that same cycle.

The bus-enable stays up until the next TPA sample that does not start another transfer. While the enable is low, the data output is held at zero so that it can be OR-combined onto a shared bus.

Top module: `dmai_req_top`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) sets dma_req_n to 1, bus_oe to 0 and bus_data to 0, and discards any pending byte.
- R2: A clock edge with enter high makes dma_req_n 0 after that edge. It remains 0 for as long as no transfer cycle is serviced.
- R3: At edges where tpa is low, state_code is ignored. Even the transfer-cycle code then leaves dma_req_n, bus_oe and bus_data unchanged.
- R4: The transfer-cycle code is state_code[0]=1 with state_code[1]=0, that is, value 2'b01. The values 2'b00, 2'b10 and 2'b11 sampled at tpa start no transfer.
- R5: An edge with tpa high, state_code 2'b01 and a request pending is a service edge. After it, bus_oe is 1, bus_data equals the captured byte, and dma_req_n is 1.
- R6: After a service edge, bus_oe stays 1 through edges where tpa is low. It drops to 0 at the next edge with tpa high that is not itself a service edge.
- R7: Whenever bus_oe is 0, bus_data is 0.
- R8: The byte is captured from in_byte at the edge where enter is high. Later changes on in_byte do not alter the byte later driven.
- R9: If enter is high at a service edge, the older byte goes out on the bus and dma_req_n stays 0. The new byte is delivered at the next service edge.
- R10: A second enter before service replaces the captured byte. Only the latest byte is delivered, in a single transfer.
- R11: A tpa sample of code 2'b01 with no request pending leaves bus_oe at 0 and dma_req_n at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_byte | input | DATA_W | Byte offered by the device |
| enter | input | 1 | One-cycle strobe: byte ready |
| state_code | input | 2 | Processor state code, valid while tpa is high |
| tpa | input | 1 | Timing pulse qualifying state_code |
| dma_req_n | output | 1 | Active-low transfer request |
| bus_data | output | DATA_W | Byte to the shared bus, zero when not enabled |
| bus_oe | output | 1 | High during the serviced transfer cycle |

## Verification
The hardest case to reach is a fresh strobe that lands on the very edge that services the previous byte. In that case the older byte must go out while the request stays asserted for the newer one. The bench sets this up by pulsing enter in the same cycle that it presents tpa with code 2'b01. It then follows with a second service to confirm that the newer byte arrives. A decoy code 2'b01 is also presented without tpa, to show that the timing qualification is honoured.

// File: rtl/dmai_pkg.sv
package dmai_pkg;
    typedef logic [1:0] sc_t;
    // Transfer-cycle state code: bit 0 high, bit 1 low
    localparam sc_t SC_XFER = 2'b01;
endpackage

// File: rtl/dmai_decode.sv
module dmai_decode
    import dmai_pkg::*;
(
    input  logic tpa,
    input  logic [1:0] state_code,
    input  logic pending,
    output logic xfer_seen,
    output logic take
);
    always_comb begin
        xfer_seen = tpa && (sc_t'(state_code) == SC_XFER);
        take      = xfer_seen && pending;
    end
endmodule

// File: rtl/dmai_hold.sv
module dmai_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enter,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              take,
    output logic [DATA_W-1:0] hold_q,
    output logic              pend_q
);
    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              pend;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (enter) begin
            st_d.hold = in_byte;
            st_d.pend = 1'b1;
        end else if (take) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hold_q = st_q.hold;
    assign pend_q = st_q.pend;

    // R2
    req_after_enter_chk: assert property (@(posedge clk) disable iff (rst)
        enter |=> pend_q);
    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !enter |=> $stable(hold_q));
endmodule

// File: rtl/dmai_drive.sv
module dmai_drive #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tpa,
    input  logic              take,
    input  logic [DATA_W-1:0] hold,
    output logic [DATA_W-1:0] data_q,
    output logic              oe_q
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              oe;
    } drv_t;

    drv_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.data = hold;
            st_d.oe   = 1'b1;
        end else if (tpa) begin
            st_d.data = '0;
            st_d.oe   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign data_q = st_q.data;
    assign oe_q   = st_q.oe;

    // R7
    quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_q |-> (data_q == '0));
    // R3
    oe_tpa_only_chk: assert property (@(posedge clk) disable iff (rst)
        !tpa |=> $stable(oe_q) && $stable(data_q));
endmodule

// File: rtl/dmai_req_top.sv
module dmai_req_top #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              enter,
    input  logic [1:0]        state_code,
    input  logic              tpa,
    output logic              dma_req_n,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe
);
    logic [DATA_W-1:0] hold_q;
    logic              pend_q;
    logic              xfer_seen;
    logic              take;

    dmai_decode u_dec (
        .tpa(tpa), .state_code(state_code), .pending(pend_q),
        .xfer_seen(xfer_seen), .take(take)
    );

    dmai_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst(rst), .enter(enter), .in_byte(in_byte),
        .take(take), .hold_q(hold_q), .pend_q(pend_q)
    );

    dmai_drive #(.DATA_W(DATA_W)) u_drv (
        .clk(clk), .rst(rst), .tpa(tpa), .take(take), .hold(hold_q),
        .data_q(bus_data), .oe_q(bus_oe)
    );

    assign dma_req_n = ~pend_q;

    // R5
    svc_grant_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> bus_oe && (bus_data == $past(hold_q)));
    // R5
    svc_release_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !enter) |=> dma_req_n);
    // R9
    svc_collide_chk: assert property (@(posedge clk) disable iff (rst)
        (take && enter) |=> !dma_req_n);
    // R11
    idle_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_seen && dma_req_n) |=> !bus_oe);
endmodule

// File: tb/dmai_req_top_test.sv
module dmai_req_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_byte = '0;
    logic       enter = 1'b0;
    logic [1:0] state_code = 2'b00;
    logic       tpa = 1'b0;
    logic       dma_req_n;
    logic [7:0] bus_data;
    logic       bus_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    dmai_req_top #(.DATA_W(8)) uut (
        .clk(clk), .rst(rst), .in_byte(in_byte), .enter(enter),
        .state_code(state_code), .tpa(tpa), .dma_req_n(dma_req_n),
        .bus_data(bus_data), .bus_oe(bus_oe)
    );

    always #10 clk = ~clk;

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply inputs for one edge, return at the following negedge
    task automatic cyc(logic en, logic [7:0] b, logic [1:0] sc, logic tp);
        enter = en; in_byte = b; state_code = sc; tpa = tp;
        @(negedge clk);
        enter = 1'b0; tpa = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cyc(0, 8'h00, 2'b00, 0);
        cyc(0, 8'h00, 2'b00, 0);
        rst = 1'b0;
        chk("R1 req_n", 8'(dma_req_n), 8'h1);
        chk("R1 oe", 8'(bus_oe), 8'h0);
        chk("R1 data", bus_data, 8'h00);
    endtask

    task automatic t_basic();
        cyc(1, 8'hA5, 2'b00, 0);
        chk("R2 req low", 8'(dma_req_n), 8'h0);
        cyc(0, 8'h3C, 2'b00, 0);
        cyc(0, 8'h3C, 2'b00, 0);
        chk("R2 held", 8'(dma_req_n), 8'h0);
        cyc(0, 8'h3C, 2'b01, 0);
        chk("R3 oe", 8'(bus_oe), 8'h0);
        chk("R3 req", 8'(dma_req_n), 8'h0);
        cyc(0, 8'h3C, 2'b00, 1);
        chk("R4 code00", 8'(bus_oe), 8'h0);
        cyc(0, 8'h3C, 2'b10, 1);
        chk("R4 code10", 8'(bus_oe), 8'h0);
        cyc(0, 8'h3C, 2'b11, 1);
        chk("R4 code11", 8'(bus_oe), 8'h0);
        chk("R4 req", 8'(dma_req_n), 8'h0);
        cyc(0, 8'h3C, 2'b01, 1);
        chk("R5 oe", 8'(bus_oe), 8'h1);
        chk("R8 data", bus_data, 8'hA5);
        chk("R5 release", 8'(dma_req_n), 8'h1);
        cyc(0, 8'h3C, 2'b01, 0);
        chk("R6 oe held", 8'(bus_oe), 8'h1);
        cyc(0, 8'h3C, 2'b00, 1);
        chk("R6 oe drop", 8'(bus_oe), 8'h0);
        chk("R7 data zero", bus_data, 8'h00);
    endtask

    task automatic t_idle();
        cyc(0, 8'h99, 2'b01, 1);
        chk("R11 oe", 8'(bus_oe), 8'h0);
        chk("R11 req", 8'(dma_req_n), 8'h1);
    endtask

    task automatic t_overwrite();
        cyc(1, 8'h11, 2'b00, 0);
        cyc(1, 8'h22, 2'b00, 0);
        cyc(0, 8'h00, 2'b01, 1);
        chk("R10 data", bus_data, 8'h22);
        chk("R10 req", 8'(dma_req_n), 8'h1);
        cyc(0, 8'h00, 2'b01, 1);
        chk("R10 single", 8'(bus_oe), 8'h0);
    endtask

    task automatic t_collide();
        cyc(1, 8'h44, 2'b00, 0);
        cyc(1, 8'h55, 2'b01, 1);
        chk("R9 old data", bus_data, 8'h44);
        chk("R9 req kept", 8'(dma_req_n), 8'h0);
        cyc(0, 8'h00, 2'b01, 1);
        chk("R9 new data", bus_data, 8'h55);
        chk("R9 release", 8'(dma_req_n), 8'h1);
        cyc(0, 8'h00, 2'b00, 1);
        chk("R6 end", 8'(bus_oe), 8'h0);
    endtask

    task automatic t_reset_mid();
        cyc(1, 8'h77, 2'b00, 0);
        rst = 1'b1;
        cyc(0, 8'h00, 2'b00, 0);
        rst = 1'b0;
        chk("R1 mid req", 8'(dma_req_n), 8'h1);
        cyc(0, 8'h00, 2'b01, 1);
        chk("R1 discarded", 8'(bus_oe), 8'h0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_idle();
        t_overwrite();
        t_collide();
        t_reset_mid();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule